// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from reset to a usable state. Once reset deasserts it waits out the power-up delay. It then sends a fixed series of commands to a downstream DDR controller: precharge all banks, load the extended mode register, load the mode register with DLL reset, and precharge all banks again. After that it turns on auto-refresh, reloads the mode register with DLL reset cleared, and lets the DLL settle. When the series is finished it reports that the memory is ready.

Each command is a 16-bit word. Bit 15 is a precharge flag, bits 14:13 select the bank and bits 12:0 carry the address. The word is presented together with a write strobe for one clock cycle. The block also gives a decoded copy of the same word, so that a controller can drive the SDRAM bank and address pins directly. Every delay is given in nanoseconds and converted to clock cycles, rounding up, from a clock-period parameter.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and on the first edge after it, the strobe, command word, refresh enable, ready flag and all decoded outputs are zero.
- R2: The first strobe comes exactly ceil(PWRUP_NS / period) clock edges after reset is released, and carries word 0x8000 (precharge all).
- R3: The second command is 0x2000, the extended mode load: bank 01, address 0, DLL on, normal drive strength.
- R4: The third command is 0x0121, a mode load for burst length 2, sequential bursts and CAS latency 2, with the DLL reset bit (address bit 8) set.
- R5: Between the first and second precharge, each strobe is followed by exactly ceil(GAP_NS / period) cycles with no strobe before the next one.
- R6: The fourth command is 0x8000. Refresh enable rises on the cycle after that strobe and stays high. The next strobe follows after exactly ceil(REFR_NS / period) more cycles.
- R7: The fifth command is 0x0021, the same mode load with the DLL reset bit cleared.
- R8: The ready flag rises ceil(DLL_NS / period) cycles after the cycle following the fifth strobe. It then stays high, and no further strobe occurs.
- R9: The strobe is never high for two cycles in a row, and the command word is zero in every cycle without a strobe.
- R10: The decoded outputs map word bits 14:13 to bank and bits 12:0 to address. When bit 15 is set, the precharge flag is high and address bit 10 is forced to 1. All decoded outputs are zero when no strobe is present.
- R11: Asserting reset at any point clears refresh enable and ready at once. After release, the full sequence starts again from the power-up wait.
- R12: A delay that is not a whole number of clock periods is rounded up to the next whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | output | 16 | Encoded command word, zero when idle |
| cmd_we | output | 1 | One-cycle command strobe |
| refresh_en | output | 1 | Allows the controller to run auto-refresh |
| init_done | output | 1 | Sequence complete, memory ready |
| pre_all | output | 1 | Decoded precharge flag |
| bank | output | 2 | Decoded bank select |
| addr | output | 13 | Decoded address, bit 10 forced on precharge |

## Verification
The bench builds the block with a 4 ns period and short delays of 1002, 101, 300 and 50 ns. Three of these are not whole multiples of the period, so the round-up rule decides the exact cycle of each strobe and of the ready flag. The short delays keep the whole sequence within a few hundred cycles. This makes it possible to check every strobe edge, the refresh turn-on, the ready point and two mid-sequence resets cycle by cycle.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;

  localparam int          STEP_W      = 3;
  localparam int          LAST_STEP   = 5;
  localparam int          REFRESH_ON  = 3;
  localparam logic [15:0] W_PRECHARGE = 16'h8000;
  localparam logic [15:0] W_EXT_MODE  = 16'h2000;
  localparam logic [15:0] W_MODE_RST  = 16'h0121;
  localparam logic [15:0] W_MODE_RUN  = 16'h0021;

  // Converts a delay in ns to whole clock cycles, rounding up, at least 1.
  function automatic int ns_to_cycles(input longint delay_ns, input longint period_ps);
    longint q;
    q = (delay_ns * 64'sd1000 + period_ps - 64'sd1) / period_ps;
    if (q < 64'sd1) q = 64'sd1;
    return int'(q);
  endfunction

  // Command word issued at each step of the sequence.
  function automatic logic [15:0] cmd_for_step(input logic [STEP_W-1:0] s);
    case (s)
      3'd0:    return W_PRECHARGE;
      3'd1:    return W_EXT_MODE;
      3'd2:    return W_MODE_RST;
      3'd3:    return W_PRECHARGE;
      3'd4:    return W_MODE_RUN;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] limit_m1,
  output logic          expired
);
  logic [CW-1:0] cnt;

  assign expired = !clear && (cnt == limit_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || expired) cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end

  // R5
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit_m1);

endmodule

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expired,
  output logic              timer_clear,
  output logic [STEP_W-1:0] step,
  output logic              issue,
  output logic              refresh_on,
  output logic              done
);
  seq_state_e state;

  assign issue       = (state == ST_ISSUE);
  assign done        = (state == ST_DONE);
  assign timer_clear = (state != ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_WAIT;
      step       <= '0;
      refresh_on <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: if (expired)
          state <= (step == STEP_W'(LAST_STEP)) ? ST_DONE : ST_ISSUE;
        ST_ISSUE: begin
          state <= ST_WAIT;
          step  <= step + STEP_W'(1);
          if (step == STEP_W'(REFRESH_ON)) refresh_on <= 1'b1;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // R9
  issue_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);
  // R6
  refresh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_on |=> refresh_on);
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

endmodule

// File: rtl/ddr_cmd_view.sv
module ddr_cmd_view (
  input  logic [15:0] word,
  output logic        pre_all,
  output logic [1:0]  bank,
  output logic [12:0] addr
);
  assign pre_all = word[15];
  assign bank    = word[14:13];
  always_comb begin
    addr = word[12:0];
    if (word[15]) addr[10] = 1'b1;
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter longint CLK_PERIOD_PS = 15000,
  parameter longint PWRUP_NS      = 200100,
  parameter longint GAP_NS        = 1000,
  parameter longint REFR_NS       = 30000,
  parameter longint DLL_NS        = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] cmd_word,
  output logic        cmd_we,
  output logic        refresh_en,
  output logic        init_done,
  output logic        pre_all,
  output logic [1:0]  bank,
  output logic [12:0] addr
);
  localparam int N_PWR  = ns_to_cycles(PWRUP_NS, CLK_PERIOD_PS);
  localparam int N_GAP  = ns_to_cycles(GAP_NS, CLK_PERIOD_PS);
  localparam int N_REFR = ns_to_cycles(REFR_NS, CLK_PERIOD_PS);
  localparam int N_DLL  = ns_to_cycles(DLL_NS, CLK_PERIOD_PS);
  localparam int N_MAX  = (N_PWR > N_REFR) ? N_PWR : N_REFR;
  localparam int CW     = $clog2(N_MAX + 1);

  logic              timer_clear, timer_expired, issue_evt, refresh_q, done_q;
  logic [STEP_W-1:0] step;
  logic [CW-1:0]     limit_m1;

  always_comb begin
    case (step)
      3'd0:    limit_m1 = CW'(N_PWR - 1);
      3'd4:    limit_m1 = CW'(N_REFR - 1);
      3'd5:    limit_m1 = CW'(N_DLL - 1);
      default: limit_m1 = CW'(N_GAP - 1);
    endcase
  end

  ddr_init_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clear),
    .limit_m1(limit_m1), .expired(timer_expired)
  );

  ddr_init_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .expired(timer_expired),
    .timer_clear(timer_clear), .step(step), .issue(issue_evt),
    .refresh_on(refresh_q), .done(done_q)
  );

  assign cmd_we     = issue_evt;
  assign cmd_word   = issue_evt ? cmd_for_step(step) : 16'h0000;
  assign refresh_en = refresh_q;
  assign init_done  = done_q;

  ddr_cmd_view u_view (
    .word(cmd_word), .pre_all(pre_all), .bank(bank), .addr(addr)
  );

  // R9
  idle_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |-> cmd_word == 16'h0000);
  // R8
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !cmd_we);
  // R10
  precharge_bank10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all |-> (cmd_we && addr[10]));
  // R6
  refresh_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> refresh_en);

endmodule

// File: tb/test_ddr_init_seq.sv
`timescale 1ns/1ps
module test_ddr_init_seq;
  localparam longint PER_PS = 4000;
  localparam longint T_PWR = 1002, T_GAP = 101, T_REFR = 300, T_DLL = 50;

  // expected command vectors: word, precharge flag, bank, address
  localparam logic [15:0] V_WORD [5] = '{16'h8000, 16'h2000, 16'h0121, 16'h8000, 16'h0021};
  localparam logic        V_PRE  [5] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [1:0]  V_BANK [5] = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0};
  localparam logic [12:0] V_ADDR [5] = '{13'h0400, 13'h0000, 13'h0121, 13'h0400, 13'h0021};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cmd_word; logic cmd_we, refresh_en, init_done, pre_all;
  logic [1:0] bank; logic [12:0] addr;
  int checks = 0, failures = 0, cur = 0;
  int e_cmd [5];
  int e_rdy;

  always #2 clk = ~clk;

  ddr_init_seq #(.CLK_PERIOD_PS(PER_PS), .PWRUP_NS(T_PWR), .GAP_NS(T_GAP),
                 .REFR_NS(T_REFR), .DLL_NS(T_DLL)) i_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_we(cmd_we),
    .refresh_en(refresh_en), .init_done(init_done), .pre_all(pre_all),
    .bank(bank), .addr(addr));

  function automatic int up_cycles(longint ns);
    longint whole = (ns * 1000) / PER_PS;
    if ((ns * 1000) % PER_PS != 0) whole = whole + 1;
    return int'(whole);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", req, cur, act, exp);
    end
  endtask

  task automatic goto_edge(int e);
    repeat (e - cur) @(posedge clk);
    #1; cur = e;
  endtask

  task automatic start();
    @(negedge clk); rst_n = 1'b1; cur = 0;
  endtask

  task automatic all_idle(string req);
    chk(req, {cmd_we, cmd_word, refresh_en, init_done, pre_all, bank, addr}, 0);
  endtask

  initial begin
    e_cmd[0] = up_cycles(T_PWR);
    for (int k = 1; k < 5; k++)
      e_cmd[k] = e_cmd[k-1] + 1 + ((k == 4) ? up_cycles(T_REFR) : up_cycles(T_GAP));
    e_rdy = e_cmd[4] + 1 + up_cycles(T_DLL);

    repeat (3) @(posedge clk); #1;
    all_idle("R1 in reset");
    start();
    goto_edge(1); all_idle("R1 after release");
    chk("R12 rounded power-up count", e_cmd[0], 251);

    for (int k = 0; k < 5; k++) begin
      goto_edge(e_cmd[k] - 1);
      chk("R5 R9 no strobe before command", {cmd_we, cmd_word}, 0);
      if (k == 3) chk("R6 refresh off before second precharge", refresh_en, 0);
      goto_edge(e_cmd[k]);
      chk("R2 R3 R4 R6 R7 strobe", cmd_we, 1);
      chk("R2 R3 R4 R6 R7 word", cmd_word, V_WORD[k]);
      chk("R10 decoded view", {pre_all, bank, addr}, {V_PRE[k], V_BANK[k], V_ADDR[k]});
      goto_edge(e_cmd[k] + 1);
      chk("R9 strobe one cycle", {cmd_we, cmd_word, pre_all, bank, addr}, 0);
      if (k == 3) chk("R6 refresh on after second precharge", refresh_en, 1);
    end

    goto_edge(e_rdy - 1);
    chk("R8 R12 not ready early", init_done, 0);
    goto_edge(e_rdy);
    chk("R8 ready", init_done, 1);
    for (int j = 1; j <= 20; j++) begin
      goto_edge(e_rdy + j);
      chk("R8 ready held, no strobe", {init_done, refresh_en, cmd_we}, 3'b110);
    end

    // reset after refresh was enabled
    rst_n = 1'b0; #1;
    all_idle("R11 async clear after done");
    start();
    goto_edge(e_cmd[3] + 10);
    chk("R6 refresh on mid sequence", refresh_en, 1);
    rst_n = 1'b0; #1;
    all_idle("R11 async clear mid sequence");
    start();
    goto_edge(e_cmd[0] - 1);
    chk("R11 restart waits full power-up", cmd_we, 0);
    goto_edge(e_cmd[0]);
    chk("R11 restart first command", {cmd_we, cmd_word}, {1'b1, 16'h8000});
    goto_edge(e_cmd[1]);
    chk("R11 R3 restart second command", cmd_word, 16'h2000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule